// File: doc/BRIEF.md
# Virtual Interrupt List Register Bank

This block holds a small set of list entries through which a hypervisor presents virtual interrupts to a guest CPU interface. Each entry records a virtual interrupt number and a two-bit lifecycle state. It also records whether the entry is tied to a physical interrupt line, and if so the physical interrupt number. The hypervisor side loads entries and can wipe them. The guest side issues acknowledge and deactivate operations.

An acknowledge picks the lowest-numbered entry that is purely pending. It moves that entry to active and returns its virtual number. If nothing is pending, it returns a spurious code. A deactivate names a virtual number and retires the matching active entry. If that entry is tied to a physical line, the block sends a one-cycle deactivate request with the physical number toward the physical distributor. Tied entries may never hold pending and active at once. A tie is also refused for interrupt classes that have no active state. Refused loads leave the entry untouched and raise an error pulse.

Top module: `vlr_bank`

## Requirements
- R1: After reset every entry is inactive, and `ackValid`, `physDeacValid` and `hvWrErr` are low.
- R2: An accepted load (`hvWrEn`) at index `hvWrIdx` replaces that entry's virtual number, state, tie flag and physical number at the next clock edge. State encoding: 0 inactive, 1 pending, 2 active, 3 pending+active.
- R3: A guest acknowledge (`gAckReq`) selects the lowest-index entry whose state is exactly pending and moves it to active. In the following cycle, `ackValid` is high for one cycle and `ackVid` carries that entry's virtual number.
- R4: An acknowledge with no entry in the pending state returns `ackVid` all ones (1023 at the default 10-bit width) and changes no entry.
- R5: A guest deactivate (`gDeacReq`, `gDeacVid`) acts on the lowest-index entry whose virtual number matches and whose state has the active bit set. Active becomes inactive, and pending+active becomes pending.
- R6: When the deactivated entry is tied, `physDeacValid` is high in the cycle after the deactivate, with `physDeacPid` equal to the stored physical number. An untied entry, or a deactivate that matches nothing, produces no request.
- R7: A load with the tie flag set and state pending+active is refused. The entry keeps its previous contents, and `hvWrErr` is high for one cycle in the following cycle.
- R8: A load with the tie flag set and `hvWrNoActive` high (a class without active state) is refused in the same way. The same load without the tie flag is accepted with no error.
- R9: A hypervisor clear (`hvClrEn`, `hvClrIdx`) forces the entry to inactive and untied at the next edge. It never produces a physical deactivate request.
- R10: When a clear and a load target the same index in the same cycle, the clear wins and the entry ends inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hvWrEn | input | 1 | Hypervisor load strobe |
| hvWrIdx | input | IDX_W | Entry index to load |
| hvWrVid | input | VID_W | Virtual interrupt number |
| hvWrState | input | 2 | Requested state (0 inactive, 1 pending, 2 active, 3 both) |
| hvWrLink | input | 1 | Tie entry to a physical line |
| hvWrPid | input | PID_W | Physical interrupt number |
| hvWrNoActive | input | 1 | Interrupt class has no active state |
| hvClrEn | input | 1 | Hypervisor clear strobe |
| hvClrIdx | input | IDX_W | Entry index to clear |
| gAckReq | input | 1 | Guest acknowledge |
| gDeacReq | input | 1 | Guest deactivate |
| gDeacVid | input | VID_W | Virtual number to deactivate |
| ackValid | output | 1 | Acknowledge response valid |
| ackVid | output | VID_W | Acknowledged virtual number or all ones |
| physDeacValid | output | 1 | Physical deactivate request |
| physDeacPid | output | PID_W | Physical number to deactivate |
| hvWrErr | output | 1 | Refused load indication |

## Verification
Some rules are checked by assertions on every cycle. A tied entry never sits in pending+active. A cleared entry is inactive on the next cycle. Every acknowledge response, physical request and error pulse follows the matching request one cycle earlier. Other behaviour can only be shown by the directed scenarios: lowest-index selection, the spurious code on an empty bank, pending+active returning to pending, the exact physical number, untouched contents after a refused load, and clear-over-load priority.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
  parameter int LR_NUM = 4;
  parameter int VID_W  = 10;
  parameter int PID_W  = 10;
  localparam int IDX_W = (LR_NUM > 1) ? $clog2(LR_NUM) : 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2,
    ST_BOTH = 2'd3
  } lrState_e;

  typedef struct packed {
    lrState_e             state;
    logic                 link;
    logic [VID_W-1:0]     vid;
    logic [PID_W-1:0]     pid;
  } lrEntry_t;

  typedef struct packed {
    logic [LR_NUM-1:0] wrHot;
    logic [LR_NUM-1:0] clrHot;
    logic [LR_NUM-1:0] ackHot;
    logic [LR_NUM-1:0] deacHot;
    lrEntry_t          wrData;
  } lrStrobe_t;
endpackage

// File: rtl/vlr_store.sv
module vlr_store
  import vlr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  lrStrobe_t                  strobe,
  output lrEntry_t [LR_NUM-1:0]      entries
);
  for (genvar i = 0; i < LR_NUM; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entries[i] <= '0;
      end else if (strobe.clrHot[i]) begin
        entries[i] <= '0;
      end else if (strobe.wrHot[i]) begin
        entries[i] <= strobe.wrData;
      end else if (strobe.ackHot[i]) begin
        entries[i].state <= ST_ACT;
      end else if (strobe.deacHot[i]) begin
        entries[i].state <= (entries[i].state == ST_BOTH) ? ST_PEND : ST_IDLE;
      end
    end

    // tied entries never hold both pending and active
    assert_link_not_both_R7: assert property (@(posedge clk) disable iff (!rstN)
      entries[i].link |-> entries[i].state != ST_BOTH);

    // a clear leaves the entry inactive
    assert_clear_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clrHot[i] |=> entries[i].state == ST_IDLE);
  end
endmodule

// File: rtl/vlr_ctrl.sv
module vlr_ctrl
  import vlr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hvWrEn,
  input  logic [IDX_W-1:0]       hvWrIdx,
  input  logic [VID_W-1:0]       hvWrVid,
  input  logic [1:0]             hvWrState,
  input  logic                   hvWrLink,
  input  logic [PID_W-1:0]       hvWrPid,
  input  logic                   hvWrNoActive,
  input  logic                   hvClrEn,
  input  logic [IDX_W-1:0]       hvClrIdx,
  input  logic                   gAckReq,
  input  logic                   gDeacReq,
  input  logic [VID_W-1:0]       gDeacVid,
  input  lrEntry_t [LR_NUM-1:0]  entries,
  output lrStrobe_t              strobe,
  output logic                   ackValid,
  output logic [VID_W-1:0]       ackVid,
  output logic                   physDeacValid,
  output logic [PID_W-1:0]       physDeacPid,
  output logic                   hvWrErr
);
  logic             wrOk;
  logic             ackFound;
  logic [IDX_W-1:0] ackSel;
  logic             deacFound;
  logic [IDX_W-1:0] deacSel;

  // load legality: a tie is refused with both states or a class lacking active
  always_comb begin
    wrOk = !(hvWrLink && ((hvWrState == 2'd3) || hvWrNoActive));
  end

  // lowest-index pending entry for acknowledge
  always_comb begin
    ackFound = 1'b0;
    ackSel   = '0;
    for (int i = LR_NUM - 1; i >= 0; i--) begin
      if (entries[i].state == ST_PEND) begin
        ackFound = 1'b1;
        ackSel   = IDX_W'(i);
      end
    end
  end

  // lowest-index active entry matching the deactivate number
  always_comb begin
    deacFound = 1'b0;
    deacSel   = '0;
    for (int i = LR_NUM - 1; i >= 0; i--) begin
      if (entries[i].state[1] && (entries[i].vid == gDeacVid)) begin
        deacFound = 1'b1;
        deacSel   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    strobe              = '0;
    strobe.wrData.state = lrState_e'(hvWrState);
    strobe.wrData.link  = hvWrLink;
    strobe.wrData.vid   = hvWrVid;
    strobe.wrData.pid   = hvWrPid;
    if (hvWrEn && wrOk && (int'(hvWrIdx) < LR_NUM))
      strobe.wrHot[hvWrIdx] = 1'b1;
    if (hvClrEn && (int'(hvClrIdx) < LR_NUM))
      strobe.clrHot[hvClrIdx] = 1'b1;
    if (gAckReq && ackFound)
      strobe.ackHot[ackSel] = 1'b1;
    if (gDeacReq && deacFound)
      strobe.deacHot[deacSel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackValid      <= 1'b0;
      ackVid        <= '0;
      physDeacValid <= 1'b0;
      physDeacPid   <= '0;
      hvWrErr       <= 1'b0;
    end else begin
      ackValid      <= gAckReq;
      ackVid        <= (gAckReq && ackFound) ? entries[ackSel].vid : '1;
      physDeacValid <= gDeacReq && deacFound && entries[deacSel].link;
      physDeacPid   <= entries[deacSel].pid;
      hvWrErr       <= hvWrEn && !wrOk;
    end
  end

  assert_ack_follows_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(gAckReq));

  assert_phys_follows_deac_R6: assert property (@(posedge clk) disable iff (!rstN)
    physDeacValid |-> $past(gDeacReq));

  assert_err_needs_link_R7: assert property (@(posedge clk) disable iff (!rstN)
    hvWrErr |-> $past(hvWrEn && hvWrLink));
endmodule

// File: rtl/vlr_bank.sv
module vlr_bank
  import vlr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hvWrEn,
  input  logic [IDX_W-1:0]   hvWrIdx,
  input  logic [VID_W-1:0]   hvWrVid,
  input  logic [1:0]         hvWrState,
  input  logic               hvWrLink,
  input  logic [PID_W-1:0]   hvWrPid,
  input  logic               hvWrNoActive,
  input  logic               hvClrEn,
  input  logic [IDX_W-1:0]   hvClrIdx,
  input  logic               gAckReq,
  input  logic               gDeacReq,
  input  logic [VID_W-1:0]   gDeacVid,
  output logic               ackValid,
  output logic [VID_W-1:0]   ackVid,
  output logic               physDeacValid,
  output logic [PID_W-1:0]   physDeacPid,
  output logic               hvWrErr
);
  lrStrobe_t             strobe;
  lrEntry_t [LR_NUM-1:0] entries;

  vlr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .hvWrEn(hvWrEn), .hvWrIdx(hvWrIdx), .hvWrVid(hvWrVid),
    .hvWrState(hvWrState), .hvWrLink(hvWrLink), .hvWrPid(hvWrPid),
    .hvWrNoActive(hvWrNoActive), .hvClrEn(hvClrEn), .hvClrIdx(hvClrIdx),
    .gAckReq(gAckReq), .gDeacReq(gDeacReq), .gDeacVid(gDeacVid),
    .entries(entries), .strobe(strobe),
    .ackValid(ackValid), .ackVid(ackVid),
    .physDeacValid(physDeacValid), .physDeacPid(physDeacPid),
    .hvWrErr(hvWrErr)
  );

  vlr_store u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .entries(entries)
  );
endmodule

// File: tb/vlr_bank_tb.sv
module vlr_bank_tb;
  import vlr_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam logic [VID_W-1:0] SPUR = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hvWrEn = 0, hvWrLink = 0, hvWrNoActive = 0, hvClrEn = 0;
  logic [IDX_W-1:0] hvWrIdx = '0, hvClrIdx = '0;
  logic [VID_W-1:0] hvWrVid = '0, gDeacVid = '0;
  logic [1:0] hvWrState = '0;
  logic [PID_W-1:0] hvWrPid = '0;
  logic gAckReq = 0, gDeacReq = 0;
  logic ackValid, physDeacValid, hvWrErr;
  logic [VID_W-1:0] ackVid;
  logic [PID_W-1:0] physDeacPid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlr_bank u_dut (
    .clk(clk), .rstN(rstN), .hvWrEn(hvWrEn), .hvWrIdx(hvWrIdx),
    .hvWrVid(hvWrVid), .hvWrState(hvWrState), .hvWrLink(hvWrLink),
    .hvWrPid(hvWrPid), .hvWrNoActive(hvWrNoActive), .hvClrEn(hvClrEn),
    .hvClrIdx(hvClrIdx), .gAckReq(gAckReq), .gDeacReq(gDeacReq),
    .gDeacVid(gDeacVid), .ackValid(ackValid), .ackVid(ackVid),
    .physDeacValid(physDeacValid), .physDeacPid(physDeacPid),
    .hvWrErr(hvWrErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one-cycle load; returns the error flag seen the cycle after
  task automatic hvWrite(input int idx, input int vid, input int st, input bit link,
                         input int pid, input bit noAct, output bit err);
    @(negedge clk);
    hvWrEn = 1; hvWrIdx = IDX_W'(idx); hvWrVid = VID_W'(vid);
    hvWrState = 2'(st); hvWrLink = link; hvWrPid = PID_W'(pid); hvWrNoActive = noAct;
    @(negedge clk);
    hvWrEn = 0; hvWrLink = 0; hvWrNoActive = 0;
    err = hvWrErr;
  endtask

  task automatic doAck(output bit vld, output int vid);
    @(negedge clk);
    gAckReq = 1;
    @(negedge clk);
    gAckReq = 0;
    vld = ackValid; vid = int'(ackVid);
  endtask

  task automatic doDeac(input int vid, output bit pv, output int pid);
    @(negedge clk);
    gDeacReq = 1; gDeacVid = VID_W'(vid);
    @(negedge clk);
    gDeacReq = 0;
    pv = physDeacValid; pid = int'(physDeacPid);
  endtask

  task automatic t_reset();
    bit v; int id;
    check(!ackValid && !physDeacValid && !hvWrErr, "R1 outputs low", int'(ackValid), 0);
    doAck(v, id);
    check(v, "R1 ack valid", int'(v), 1);
    check(id == int'(SPUR), "R1 R4 empty bank spurious", id, int'(SPUR));
  endtask

  task automatic t_ackOrder();
    bit e, v; int id;
    hvWrite(2, 'h22, 1, 0, 0, 0, e);
    check(!e, "R2 accepted load", int'(e), 0);
    hvWrite(1, 'h11, 1, 0, 0, 0, e);
    doAck(v, id);
    check(id == 'h11, "R3 lowest index first", id, 'h11);
    doAck(v, id);
    check(id == 'h22, "R3 next pending", id, 'h22);
    doAck(v, id);
    check(v && id == int'(SPUR), "R4 none pending", id, int'(SPUR));
  endtask

  task automatic t_deac();
    bit e, pv, v; int pid, id;
    doDeac('h11, pv, pid);
    check(!pv, "R6 untied no request", int'(pv), 0);
    hvWrite(0, 5, 3, 0, 0, 0, e);
    check(!e, "R2 untied both accepted", int'(e), 0);
    doDeac(5, pv, pid);
    doAck(v, id);
    check(id == 5, "R5 both returns to pending", id, 5);
    doDeac(5, pv, pid);
    doAck(v, id);
    check(id == int'(SPUR), "R5 active to inactive", id, int'(SPUR));
    doDeac('h3AB, pv, pid);
    check(!pv, "R6 no match no request", int'(pv), 0);
  endtask

  task automatic t_link();
    bit e, pv, v; int pid, id;
    hvWrite(3, 'h33, 1, 1, 'h155, 0, e);
    check(!e, "R2 tied pending accepted", int'(e), 0);
    doAck(v, id);
    check(id == 'h33, "R3 tied ack", id, 'h33);
    doDeac('h33, pv, pid);
    check(pv, "R6 tied request", int'(pv), 1);
    check(pid == 'h155, "R6 physical number", pid, 'h155);
    @(negedge clk);
    check(!physDeacValid, "R6 single cycle", int'(physDeacValid), 0);
  endtask

  task automatic t_reject();
    bit e, v; int id;
    hvWrite(0, 'h40, 1, 0, 0, 0, e);
    hvWrite(0, 'h41, 3, 1, 7, 0, e);
    check(e, "R7 tied both refused", int'(e), 1);
    @(negedge clk);
    check(!hvWrErr, "R7 error one cycle", int'(hvWrErr), 0);
    doAck(v, id);
    check(id == 'h40, "R7 entry unchanged", id, 'h40);
    hvWrite(0, 'h42, 1, 1, 9, 1, e);
    check(e, "R8 tie on no-active class refused", int'(e), 1);
    doAck(v, id);
    check(id == int'(SPUR), "R8 entry unchanged", id, int'(SPUR));
    hvWrite(0, 'h43, 1, 0, 0, 1, e);
    check(!e, "R8 untied no-active accepted", int'(e), 0);
    doAck(v, id);
    check(id == 'h43, "R8 untied load stored", id, 'h43);
  endtask

  task automatic t_clear();
    bit e, pv, v; int pid, id;
    hvWrite(1, 'h60, 2, 1, 'hAA, 0, e);
    @(negedge clk);
    hvClrEn = 1; hvClrIdx = 1;
    @(negedge clk);
    hvClrEn = 0;
    check(!physDeacValid, "R9 clear no request", int'(physDeacValid), 0);
    doDeac('h60, pv, pid);
    check(!pv, "R9 cleared entry gone", int'(pv), 0);
    @(negedge clk);
    hvClrEn = 1; hvClrIdx = 2;
    hvWrEn = 1; hvWrIdx = 2; hvWrVid = 'h70; hvWrState = 1;
    @(negedge clk);
    hvClrEn = 0; hvWrEn = 0;
    doAck(v, id);
    check(id == int'(SPUR), "R10 clear beats load", id, int'(SPUR));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_ackOrder();
    t_deac();
    t_link();
    t_reject();
    t_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule